// File: doc/BRIEF.md
# CPU and DMA Bus Slot Arbiter

This block decides, every clock cycle, which agent drives a shared memory bus: a general DMA source, a blitter, or a CPU. General DMA always wins. The blitter comes next, and the CPU takes whatever slots are left. A CPU memory access is a fixed transaction of four granted bus cycles. An access may begin only on an even cycle of a free-running two-cycle slot phase. Cycles taken by DMA in the middle of an access stretch that access; they never abort it. Accesses are not pipelined, so the CPU can never finish more than one access per four cycles. When an access ends on an even cycle, the odd cycle that follows is lost to the CPU.

A blitter-priority input picks how the blitter treats the CPU. When it is high, a requesting blitter takes every slot that general DMA leaves free, and the CPU waits for as long as the blitter keeps asking. When it is low, the blitter gives one slot to the CPU after the CPU has lost three slots it wanted to the blitter in a row. The CPU wants a slot when it is inside an access, or when it has a pending request and the cycle is even.

The CPU side is a valid/ready handshake. The CPU raises `cpu_req_valid` and must hold it until `cpu_req_ready` is high at a rising edge. Ready is high only in the cycle of the fourth granted cycle, which is when the access completes. There is no other back-pressure. The DMA and blitter requests are plain levels, and each is served in the same cycle it is raised.

Top module: `bus_slot_arbiter`

## Requirements
- R1: At most one of `grant_cpu`, `grant_blit` and `grant_dma` is high in any cycle. All three are low when nothing requests the bus.
- R2: Whenever `dma_req` is high, `grant_dma` is high in that same cycle.
- R3: The slot phase is 0 in the first cycle after reset is released and alternates every cycle after that. A new CPU access (a CPU grant while no access is in progress) begins only when the phase is 0. A request raised in a phase-1 cycle gets no grant in that cycle.
- R4: A CPU access completes on its fourth CPU-granted cycle. `cpu_req_ready` is high in exactly that cycle.
- R5: A cycle taken by DMA during a CPU access delays the access but does not abort it. The access still needs four CPU grants in total.
- R6: After an access completes, the next access waits for the next phase-0 cycle. The odd cycle right after an access that ends in phase 0 gets no CPU grant.
- R7: With `blit_pri` high and `dma_req` low, `blit_req` high gives `grant_blit`, whatever the CPU is requesting.
- R8: With `blit_pri` low, after the CPU has lost three slots it wanted to the blitter, the next slot the CPU wants, if not taken by DMA, goes to the CPU.
- R9: `cpu_wait` is high in every cycle in which `cpu_req_valid` is high and the access does not complete in that cycle. It is low when there is no request.
- R10: During reset, all grants, `cpu_req_ready` and `cpu_wait` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| blit_pri | input | 1 | High: the blitter never gives slots to the CPU |
| cpu_req_valid | input | 1 | CPU access request; held until ready |
| cpu_req_ready | output | 1 | Access completes this cycle |
| cpu_wait | output | 1 | Requested access not yet complete |
| blit_req | input | 1 | Blitter wants this slot |
| dma_req | input | 1 | General DMA wants this slot (highest priority) |
| grant_cpu | output | 1 | Bus belongs to the CPU this cycle |
| grant_blit | output | 1 | Bus belongs to the blitter this cycle |
| grant_dma | output | 1 | Bus belongs to general DMA this cycle |

## Verification
Grants, `cpu_wait` and `cpu_req_ready` are combinational from the current requests and registered state, so each result is due in the same cycle as the stimulus that causes it. The bench drives inputs on the falling edge and samples one time unit later, before the next rising edge. It counts rising edges since reset, so it always knows the slot phase and can predict the exact cycle of each CPU grant, each stretched completion and the CPU's forced slot when the blitter has kept it out.

// File: rtl/bus_arb_pkg.sv
package bus_arb_pkg;
  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_CPU  = 2'd1,
    OWN_BLIT = 2'd2,
    OWN_DMA  = 2'd3
  } bus_owner_e;
endpackage

// File: rtl/bus_arb_phase.sv
// Free-running slot phase; a CPU access may start only where it reads zero.
module bus_arb_phase #(
  parameter int ALIGN = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic phase_zero
);
  localparam int PW = (ALIGN > 1) ? $clog2(ALIGN) : 1;
  localparam logic [PW-1:0] LAST = PW'(ALIGN - 1);

  logic [PW-1:0] phase_q;

  generate
    if (ALIGN > 1) begin : g_count
      always_ff @(posedge clk) begin
        if (!rst_n)              phase_q <= '0;
        else if (phase_q == LAST) phase_q <= '0;
        else                     phase_q <= phase_q + 1'b1;
      end
    end else begin : g_flat
      always_ff @(posedge clk) phase_q <= '0;
    end
  endgenerate

  assign phase_zero = (phase_q == '0);
endmodule

// File: rtl/bus_arb_cpu_seq.sv
// Tracks the granted cycles of one CPU access; stolen cycles leave it unchanged.
module bus_arb_cpu_seq #(
  parameter int BEATS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic grant_cpu,
  output logic active,
  output logic done
);
  localparam int BW = $clog2(BEATS + 1);
  localparam logic [BW-1:0] FINAL = BW'(BEATS - 1);

  logic [BW-1:0] beat_q;
  logic          active_q;
  logic          at_final;

  assign at_final = active_q ? (beat_q == FINAL) : (BEATS == 1);
  assign done     = grant_cpu && at_final;
  assign active   = active_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      beat_q   <= '0;
    end else if (grant_cpu) begin
      if (at_final) begin
        active_q <= 1'b0;
        beat_q   <= '0;
      end else begin
        active_q <= 1'b1;
        beat_q   <= beat_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/bus_arb_starve.sv
// Counts the slots the CPU wanted but lost to the blitter; flags when the CPU is owed one.
module bus_arb_starve #(
  parameter int LIMIT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic blit_pri,
  input  logic cpu_wants,
  input  logic grant_cpu,
  input  logic grant_blit,
  output logic owed
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] TOP = CW'(LIMIT);

  logic [CW-1:0] lost_q;

  always_ff @(posedge clk) begin
    if (!rst_n || blit_pri)            lost_q <= '0;
    else if (grant_cpu)                lost_q <= '0;
    else if (cpu_wants && grant_blit && lost_q != TOP)
                                       lost_q <= lost_q + 1'b1;
  end

  assign owed = !blit_pri && (lost_q == TOP);
endmodule

// File: rtl/bus_arb_pick.sv
// Per-cycle priority: general DMA, then the blitter (unless the CPU is owed a slot), then the CPU.
module bus_arb_pick
  import bus_arb_pkg::*;
(
  input  logic       dma_req,
  input  logic       blit_req,
  input  logic       cpu_wants,
  input  logic       cpu_owed,
  output bus_owner_e owner
);
  always_comb begin
    if (dma_req)                                 owner = OWN_DMA;
    else if (cpu_wants && (!blit_req || cpu_owed)) owner = OWN_CPU;
    else if (blit_req)                           owner = OWN_BLIT;
    else                                         owner = OWN_NONE;
  end
endmodule

// File: rtl/bus_slot_arbiter.sv
module bus_slot_arbiter
  import bus_arb_pkg::*;
#(
  parameter int CPU_BEATS   = 4,
  parameter int START_ALIGN = 2,
  parameter int STARVE_MAX  = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic blit_pri,
  input  logic cpu_req_valid,
  output logic cpu_req_ready,
  output logic cpu_wait,
  input  logic blit_req,
  input  logic dma_req,
  output logic grant_cpu,
  output logic grant_blit,
  output logic grant_dma
);
  logic       phase_zero;
  logic       cpu_active;
  logic       cpu_done;
  logic       cpu_wants;
  logic       cpu_owed;
  bus_owner_e owner;

  bus_arb_phase #(.ALIGN(START_ALIGN)) u_phase (
    .clk(clk), .rst_n(rst_n), .phase_zero(phase_zero)
  );

  assign cpu_wants = rst_n && (cpu_active || (cpu_req_valid && phase_zero));

  bus_arb_pick u_pick (
    .dma_req  (dma_req && rst_n),
    .blit_req (blit_req && rst_n),
    .cpu_wants(cpu_wants),
    .cpu_owed (cpu_owed),
    .owner    (owner)
  );

  assign grant_cpu  = (owner == OWN_CPU);
  assign grant_blit = (owner == OWN_BLIT);
  assign grant_dma  = (owner == OWN_DMA);

  bus_arb_cpu_seq #(.BEATS(CPU_BEATS)) u_seq (
    .clk(clk), .rst_n(rst_n), .grant_cpu(grant_cpu),
    .active(cpu_active), .done(cpu_done)
  );

  bus_arb_starve #(.LIMIT(STARVE_MAX)) u_starve (
    .clk(clk), .rst_n(rst_n), .blit_pri(blit_pri),
    .cpu_wants(cpu_wants), .grant_cpu(grant_cpu), .grant_blit(grant_blit),
    .owed(cpu_owed)
  );

  assign cpu_req_ready = cpu_done;
  assign cpu_wait      = rst_n && cpu_req_valid && !cpu_done;
endmodule

// File: rtl/bus_slot_arbiter_chk.sv
module bus_slot_arbiter_chk (
  input logic clk,
  input logic rst_n,
  input logic blit_pri,
  input logic cpu_req_valid,
  input logic cpu_req_ready,
  input logic cpu_wait,
  input logic blit_req,
  input logic dma_req,
  input logic grant_cpu,
  input logic grant_blit,
  input logic grant_dma,
  input logic cpu_active,
  input logic phase_zero,
  input logic cpu_wants
);
  logic [2:0] lost_cnt;
  logic       seen_edge;

  always_ff @(posedge clk) begin
    if (!rst_n) seen_edge <= 1'b0;
    else        seen_edge <= 1'b1;
    if (!rst_n || blit_pri || grant_cpu) lost_cnt <= '0;
    else if (cpu_wants && grant_blit && lost_cnt != 3'd7) lost_cnt <= lost_cnt + 1'b1;
  end

  assert_grant_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({grant_cpu, grant_blit, grant_dma}));

  assert_dma_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> grant_dma);

  assert_start_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_cpu && !cpu_active) |-> phase_zero);

  assert_ready_on_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req_ready |-> grant_cpu);

  assert_ready_ends_access_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req_ready |=> !cpu_active);

  assert_steal_keeps_access_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_active && dma_req) |=> cpu_active);

  assert_restart_aligned_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_edge && $past(cpu_req_ready) && grant_cpu) |-> phase_zero);

  assert_blit_priority_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (blit_pri && blit_req && !dma_req) |-> grant_blit);

  assert_starve_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!blit_pri && lost_cnt >= 3'd3 && cpu_wants && !dma_req) |-> grant_cpu);

  assert_wait_shown_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req_valid && !grant_cpu) |-> cpu_wait);

  always_comb begin
    if (!rst_n) assert_quiet_in_reset_R10: assert (!grant_cpu && !grant_blit && !grant_dma && !cpu_wait);
  end
endmodule

bind bus_slot_arbiter bus_slot_arbiter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .blit_pri(blit_pri), .cpu_req_valid(cpu_req_valid),
  .cpu_req_ready(cpu_req_ready), .cpu_wait(cpu_wait), .blit_req(blit_req),
  .dma_req(dma_req), .grant_cpu(grant_cpu), .grant_blit(grant_blit),
  .grant_dma(grant_dma), .cpu_active(cpu_active), .phase_zero(phase_zero),
  .cpu_wants(cpu_wants)
);

// File: tb/bus_slot_arbiter_test.sv
module bus_slot_arbiter_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic blit_pri = 1'b0;
  logic cpu_req_valid = 1'b0;
  logic blit_req = 1'b0;
  logic dma_req = 1'b0;
  logic cpu_req_ready, cpu_wait, grant_cpu, grant_blit, grant_dma;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  bus_slot_arbiter uut (
    .clk(clk), .rst_n(rst_n), .blit_pri(blit_pri),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready), .cpu_wait(cpu_wait),
    .blit_req(blit_req), .dma_req(dma_req),
    .grant_cpu(grant_cpu), .grant_blit(grant_blit), .grant_dma(grant_dma)
  );

  // owner code: 0 none, 1 cpu, 2 blit, 3 dma
  function automatic int owner_now();
    return grant_dma ? 3 : grant_blit ? 2 : grant_cpu ? 1 : 0;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Sample the state just after the inputs were set on the falling edge.
  task automatic look(input string req, input int exp_owner, input bit exp_ready, input bit exp_wait);
    #1;
    check(owner_now() == exp_owner, req, owner_now(), exp_owner);
    check(cpu_req_ready == exp_ready, {req, " ready"}, cpu_req_ready, exp_ready);
    check(cpu_wait == exp_wait, {req, " wait"}, cpu_wait, exp_wait);
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic to_parity(input int p);
    while ((cyc % 2) != p) step();
  endtask

  task automatic quiet();
    cpu_req_valid = 0; blit_req = 0; dma_req = 0; blit_pri = 0;
    step(); step(); step(); step();
  endtask

  task automatic t_reset();
    cpu_req_valid = 1; blit_req = 1; dma_req = 1;
    #1;
    check(!grant_cpu && !grant_blit && !grant_dma, "R10 grants", owner_now(), 0);
    check(!cpu_wait, "R10 wait", cpu_wait, 0);
    cpu_req_valid = 0; blit_req = 0; dma_req = 0;
    @(negedge clk); rst_n = 1;
    #1;
    check(owner_now() == 0, "R1 idle", owner_now(), 0);
    step();
  endtask

  task automatic t_single();
    to_parity(0);
    cpu_req_valid = 1;
    for (int i = 0; i < 4; i++) begin
      look("R4 single", 1, i == 3, i != 3);
      step();
    end
    cpu_req_valid = 0;
    look("R9 released", 0, 0, 0);
    quiet();
  endtask

  task automatic t_odd_start();
    to_parity(1);
    cpu_req_valid = 1;
    look("R3 odd", 0, 0, 1);
    step();
    for (int i = 0; i < 4; i++) begin
      look("R3 after align", 1, i == 3, i != 3);
      step();
    end
    cpu_req_valid = 0;
    quiet();
  endtask

  task automatic t_steal_and_gap();
    to_parity(0);
    cpu_req_valid = 1;
    look("R5 beat1", 1, 0, 1); step();
    look("R5 beat2", 1, 0, 1); step();
    dma_req = 1;
    look("R2 steal", 3, 0, 1); step();
    dma_req = 0;
    look("R5 beat3", 1, 0, 1); step();
    look("R5 beat4", 1, 1, 0); step();
    // valid held high: a new request, now in an odd cycle
    look("R6 gap", 0, 0, 1); step();
    look("R6 restart", 1, 0, 1); step();
    look("R6 beat2", 1, 0, 1); step();
    look("R6 beat3", 1, 0, 1); step();
    look("R6 beat4", 1, 1, 0); step();
    look("R6 back2back", 1, 0, 1); step();
    cpu_req_valid = 0;
    // leave the access unfinished only with valid low: finish it quietly
    for (int i = 0; i < 3; i++) step();
    quiet();
  endtask

  task automatic t_blit_pri();
    to_parity(0);
    blit_pri = 1; blit_req = 1; cpu_req_valid = 1;
    for (int i = 0; i < 8; i++) begin
      look("R7 locked", 2, 0, 1);
      step();
    end
    blit_req = 0;
    look("R7 release", 1, 0, 1);
    for (int i = 0; i < 4; i++) step();
    cpu_req_valid = 0; blit_pri = 0;
    quiet();
  endtask

  task automatic t_blit_yield();
    to_parity(0);
    blit_pri = 0; blit_req = 1; cpu_req_valid = 1;
    for (int i = 0; i < 6; i++) begin
      look("R8 blit holds", 2, 0, 1);
      step();
    end
    look("R8 cpu owed start", 1, 0, 1); step();
    for (int i = 0; i < 3; i++) begin
      look("R8 blit again", 2, 0, 1);
      step();
    end
    look("R8 cpu owed beat2", 1, 0, 1); step();
    blit_req = 0;
    look("R1 cpu beat3", 1, 0, 1); step();
    look("R4 cpu beat4", 1, 1, 0); step();
    cpu_req_valid = 0;
    look("R1 none", 0, 0, 0);
    quiet();
  endtask

  task automatic t_dma_over_blit();
    blit_req = 1; dma_req = 1; blit_pri = 1;
    look("R2 over blit", 3, 0, 0); step();
    dma_req = 0;
    look("R7 blit only", 2, 0, 0); step();
    quiet();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    t_reset();
    t_single();
    t_odd_start();
    t_steal_and_gap();
    t_blit_pri();
    t_blit_yield();
    t_dma_over_blit();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule